// File: doc/BRIEF.md
# Bus Controller Message Sequencer

This block is the control state machine of a MIL-STD-1553 bus controller. It sits between a register file, which supplies two command words and a mode bit, and abstract word-level transmit and receive channels. Manchester coding, the analog bus and bit timing belong to those channels, not to this block. A rising edge on `start` makes the block send the first command word. In RT-to-RT mode it then sends the second command word, the transmit command. If the command needs data from the controller, the block pulls data words from a transmit FIFO. It then collects the response: status words, followed by any data words, which it pushes into a receive FIFO.

Every message ends with one of two flags. `valmess` means the exchange was correct. `error` means something went wrong, and a bit field gives the cause. If a data word arrives after a message has already completed correctly, the valid flag is withdrawn and an error is raised in its place. A new start clears both flags and all error bits.

The command word layout is the standard one. Bits 15:11 hold the RT address, bit 10 is transmit/receive (1 means the RT transmits), bits 9:5 hold the subaddress and bits 4:0 hold the word count or mode code. The `rt_to_rt`, `cmd1_word`, `cmd2_word` and `resp_timeout` inputs must stay stable while a message runs.

Top module: `bc_msg_seq`

## Requirements
- R1: A 0-to-1 transition of `start`, seen while no message is running, sends `cmd1_word` with `tx_cmd`=1. With `rt_to_rt`=1, `cmd2_word` follows as a second command word. A level held high starts only one message. The start clears `valmess`, `error` and `err_flags`.
- R2: When the controller supplies data, each data word is `tx_fifo_word` sent with `tx_cmd`=0, with one `tx_pop` per accepted word. This happens for a receive command (bit 10 = 0), which sends the word count (bits 4:0, where 0 means 32). It also happens for a mode command (subaddress 0 or 31) whose code bit 4 is set and whose bit 10 is 0, which sends one word.
- R3: A command to address 31 outside RT-to-RT mode awaits no status. `valmess` rises after the last transmitted word.
- R4: The status of the responding RT is stored in `stat1`. In RT-to-RT mode, the status of the transmitting RT (addressed by `cmd2_word`) is stored in `stat2`, and the status of the receiving RT is stored in `stat1`.
- R5: Each accepted received data word is passed unchanged to `rxf_word`, with one `rxf_push` per word. The expected count comes from the word count or mode code field of the command whose RT transmits.
- R6: Every message ends with exactly one of `valmess` or `error`. The two flags are never high together.
- R7: `err_flags` uses bit 0 for no response, bit 1 for address mismatch, bit 2 for a word flagged bad by the decoder, bit 3 for wrong sync type, and bit 4 for word count. `error` is high exactly when some bit is set.
- R8: If no status word arrives within `resp_timeout` cycles, the message ends with bit 0.
- R9: A status word whose bits 15:11 differ from the addressed RT ends the message with bit 1.
- R10: If data words stop for longer than `resp_timeout` before the count is met, the message ends with bit 4.
- R11: A data word that arrives while `valmess` is high clears `valmess`, sets `error` and sets bit 4.
- R12: A status word with `rx_bad`=1 ends the message with bit 2. A status word carrying data sync (`rx_stat_sync`=0) ends it with bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Message start, acts on its rising edge |
| rt_to_rt | input | 1 | Selects an RT-to-RT transfer |
| cmd1_word | input | 16 | First command word (the receive command in RT-to-RT mode) |
| cmd2_word | input | 16 | Transmit command word for RT-to-RT mode |
| resp_timeout | input | TO_W | Response and inter-word timeout, in cycles |
| tx_valid | output | 1 | A word is offered to the transmitter |
| tx_cmd | output | 1 | The offered word takes command sync |
| tx_word | output | 16 | Offered word |
| tx_ready | input | 1 | The transmitter accepts the offered word |
| tx_pop | output | 1 | Pops the transmit FIFO head |
| tx_fifo_word | input | 16 | Transmit FIFO head |
| rx_valid | input | 1 | A decoded word is present for one cycle |
| rx_stat_sync | input | 1 | The word had status sync (1) or data sync (0) |
| rx_bad | input | 1 | The decoder flagged an encoding or parity fault |
| rx_word | input | 16 | Decoded word |
| rxf_push | output | 1 | Writes `rxf_word` into the receive FIFO |
| rxf_word | output | 16 | Data word for the receive FIFO |
| stat1 | output | 16 | Status word register 1 |
| stat2 | output | 16 | Status word register 2 |
| valmess | output | 1 | Message completed correctly |
| error | output | 1 | Message ended in error |
| err_flags | output | 5 | Error cause bits |

## Verification
The main function is exercised with each message shape. The shapes are a receive command, a 32-word transmit command, a broadcast receive, transmit and receive mode codes that carry one data word, a mode code without data, and an RT-to-RT transfer. Together they separate the decision of who supplies the data, and how many words, from the decision of whether and where a status word is awaited. Each fault is then applied to an otherwise good message: silence, a wrong address, a short data burst, a bad word, a wrong sync and an extra word after completion. This checks that each fault maps to its own error bit and that the valid flag never coexists with it. A held-high start shows that only the edge triggers a message.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int WORD_W   = 16;
  localparam int ERR_W    = 5;
  localparam int CNT_W    = 6;

  // error bit positions
  localparam int E_NORESP = 0;
  localparam int E_ADDR   = 1;
  localparam int E_BAD    = 2;
  localparam int E_SYNC   = 3;
  localparam int E_COUNT  = 4;

  localparam logic [4:0] BCAST_RT = 5'd31;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_CMD2, S_TXD, S_STS_A, S_RXD, S_STS_B, S_FIN
  } seq_state_t;

  typedef struct packed {
    logic [4:0]       rt;
    logic             xmit;
    logic             bcast;
    logic [CNT_W-1:0] nwords;
  } cmd_info_t;

endpackage

// File: rtl/bcs_cmd_decode.sv
module bcs_cmd_decode
  import bcs_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output cmd_info_t         info
);

  logic [4:0] sub_addr;
  logic [4:0] cnt_field;
  logic       is_mode;

  assign sub_addr  = cmd[9:5];
  assign cnt_field = cmd[4:0];
  assign is_mode   = (sub_addr == 5'd0) || (sub_addr == 5'd31);

  always_comb begin
    info.rt    = cmd[15:11];
    info.xmit  = cmd[10];
    info.bcast = (cmd[15:11] == BCAST_RT);
    if (is_mode) begin
      info.nwords = cnt_field[4] ? CNT_W'(1) : CNT_W'(0);
    end else if (cnt_field == 5'd0) begin
      info.nwords = CNT_W'(32);
    end else begin
      info.nwords = CNT_W'(cnt_field);
    end
  end

endmodule

// File: rtl/bcs_resp_timer.sv
module bcs_resp_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run || restart) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != limit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && !restart && (cnt_q == limit);

endmodule

// File: rtl/bc_msg_seq.sv
module bc_msg_seq
  import bcs_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rt_to_rt,
  input  logic [15:0]       cmd1_word,
  input  logic [15:0]       cmd2_word,
  input  logic [TO_W-1:0]   resp_timeout,
  output logic              tx_valid,
  output logic              tx_cmd,
  output logic [15:0]       tx_word,
  input  logic              tx_ready,
  output logic              tx_pop,
  input  logic [15:0]       tx_fifo_word,
  input  logic              rx_valid,
  input  logic              rx_stat_sync,
  input  logic              rx_bad,
  input  logic [15:0]       rx_word,
  output logic              rxf_push,
  output logic [15:0]       rxf_word,
  output logic [15:0]       stat1,
  output logic [15:0]       stat2,
  output logic              valmess,
  output logic              error,
  output logic [ERR_W-1:0]  err_flags
);

  localparam int NCMD = 2;

  logic [WORD_W-1:0] cmd_vec [NCMD];
  cmd_info_t         info    [NCMD];

  assign cmd_vec[0] = cmd1_word;
  assign cmd_vec[1] = cmd2_word;

  for (genvar gi = 0; gi < NCMD; gi++) begin : g_dec
    bcs_cmd_decode u_dec (
      .cmd  (cmd_vec[gi]),
      .info (info[gi])
    );
  end

  logic unused_c2;
  assign unused_c2 = ^{info[1].xmit, info[1].bcast};

  // state and registers
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             val_q, val_d;
  logic             err_q, err_d;
  logic [ERR_W-1:0] eb_q, eb_d;
  logic [15:0]      s1_q, s2_q;
  logic             s1_en, s2_en;
  logic             start_q;
  logic             start_rise;
  logic             expired;
  logic             tmr_run;
  logic             bc_sends;
  logic [4:0]       exp_rt_a;
  logic [CNT_W-1:0] rx_count;

  assign start_rise = start && !start_q;
  assign tmr_run    = (state_q == S_STS_A) || (state_q == S_RXD) || (state_q == S_STS_B);
  assign bc_sends   = !info[0].xmit && (info[0].nwords != '0);
  assign exp_rt_a   = rt_to_rt ? info[1].rt : info[0].rt;
  assign rx_count   = rt_to_rt ? info[1].nwords : info[0].nwords;

  bcs_resp_timer #(.TO_W(TO_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .restart (rx_valid),
    .limit   (resp_timeout),
    .expired (expired)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    val_d    = val_q;
    err_d    = err_q;
    eb_d     = eb_q;
    s1_en    = 1'b0;
    s2_en    = 1'b0;
    tx_valid = 1'b0;
    tx_cmd   = 1'b0;
    tx_word  = '0;
    tx_pop   = 1'b0;
    rxf_push = 1'b0;

    case (state_q)
      S_IDLE, S_FIN: begin
        if (start_rise) begin
          state_d = S_CMD1;
          val_d   = 1'b0;
          err_d   = 1'b0;
          eb_d    = '0;
        end else if (state_q == S_FIN && val_q && rx_valid && !rx_stat_sync) begin
          val_d          = 1'b0;
          err_d          = 1'b1;
          eb_d[E_COUNT]  = 1'b1;
        end
      end

      S_CMD1: begin
        tx_valid = 1'b1;
        tx_cmd   = 1'b1;
        tx_word  = cmd1_word;
        if (tx_ready) begin
          if (rt_to_rt) begin
            state_d = S_CMD2;
          end else if (bc_sends) begin
            state_d = S_TXD;
            cnt_d   = info[0].nwords;
          end else if (info[0].bcast) begin
            state_d = S_FIN;
            val_d   = 1'b1;
          end else begin
            state_d = S_STS_A;
          end
        end
      end

      S_CMD2: begin
        tx_valid = 1'b1;
        tx_cmd   = 1'b1;
        tx_word  = cmd2_word;
        if (tx_ready) begin
          state_d = S_STS_A;
        end
      end

      S_TXD: begin
        tx_valid = 1'b1;
        tx_word  = tx_fifo_word;
        if (tx_ready) begin
          tx_pop = 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            if (info[0].bcast) begin
              state_d = S_FIN;
              val_d   = 1'b1;
            end else begin
              state_d = S_STS_A;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end

      S_STS_A, S_STS_B: begin
        if (rx_valid) begin
          if (rx_bad) begin
            state_d     = S_FIN;
            err_d       = 1'b1;
            eb_d[E_BAD] = 1'b1;
          end else if (!rx_stat_sync) begin
            state_d      = S_FIN;
            err_d        = 1'b1;
            eb_d[E_SYNC] = 1'b1;
          end else begin
            s2_en = (state_q == S_STS_A) && rt_to_rt;
            s1_en = !s2_en;
            if (rx_word[15:11] != ((state_q == S_STS_A) ? exp_rt_a : info[0].rt)) begin
              state_d      = S_FIN;
              err_d        = 1'b1;
              eb_d[E_ADDR] = 1'b1;
            end else if (state_q == S_STS_A &&
                         (rt_to_rt || (info[0].xmit && info[0].nwords != '0))) begin
              state_d = S_RXD;
              cnt_d   = rx_count;
            end else begin
              state_d = S_FIN;
              val_d   = 1'b1;
            end
          end
        end else if (expired) begin
          state_d        = S_FIN;
          err_d          = 1'b1;
          eb_d[E_NORESP] = 1'b1;
        end
      end

      S_RXD: begin
        if (rx_valid) begin
          if (rx_bad) begin
            state_d     = S_FIN;
            err_d       = 1'b1;
            eb_d[E_BAD] = 1'b1;
          end else if (rx_stat_sync) begin
            state_d      = S_FIN;
            err_d        = 1'b1;
            eb_d[E_SYNC] = 1'b1;
          end else begin
            rxf_push = 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              if (rt_to_rt && !info[0].bcast) begin
                state_d = S_STS_B;
              end else begin
                state_d = S_FIN;
                val_d   = 1'b1;
              end
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end else if (expired) begin
          state_d       = S_FIN;
          err_d         = 1'b1;
          eb_d[E_COUNT] = 1'b1;
        end
      end

      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      val_q   <= 1'b0;
      err_q   <= 1'b0;
      eb_q    <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      val_q   <= val_d;
      err_q   <= err_d;
      eb_q    <= eb_d;
      start_q <= start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
    end else if (s1_en) begin
      s1_q <= rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q <= '0;
    end else if (s2_en) begin
      s2_q <= rx_word;
    end
  end

  assign rxf_word  = rx_word;
  assign stat1     = s1_q;
  assign stat2     = s2_q;
  assign valmess   = val_q;
  assign error     = err_q;
  assign err_flags = eb_q;

endmodule

// File: rtl/bcs_sva.sv
module bcs_sva
  import bcs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rx_valid,
  input logic             rx_stat_sync,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_cmd,
  input logic             tx_pop,
  input logic             rxf_push,
  input logic             valmess,
  input logic             error,
  input logic [ERR_W-1:0] err_flags
);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(valmess && error)); // R6

  AST_ERR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    error == (err_flags != '0)); // R7

  AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_valid && tx_ready && !tx_cmd)); // R2

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> (rx_valid && !rx_stat_sync)); // R5

  AST_NO_TX_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (valmess || error) |-> !tx_valid); // R1

  AST_VAL_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valmess) |-> (error || $past(start))); // R11

endmodule

bind bc_msg_seq bcs_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rx_valid     (rx_valid),
  .rx_stat_sync (rx_stat_sync),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_cmd       (tx_cmd),
  .tx_pop       (tx_pop),
  .rxf_push     (rxf_push),
  .valmess      (valmess),
  .error        (error),
  .err_flags    (err_flags)
);

// File: tb/tb_bc_msg_seq.sv
module tb_bc_msg_seq;

  localparam int TO_W = 16;
  localparam int NV   = 13;

  function automatic logic [15:0] mk(input int rt, input int tr, input int sa, input int wc);
    return {5'(rt), 1'(tr), 5'(sa), 5'(wc)};
  endfunction

  // {rt2rt, cmd1, cmd2, fault, expected err_flags}
  // fault: 0 none, 1 silent, 2 wrong addr, 3 short, 4 bad word, 5 wrong sync, 6 extra word
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, mk(5,0,2,3),  16'h0, 3'd0, 5'd0},
    {1'b0, mk(7,1,4,0),  16'h0, 3'd0, 5'd0},
    {1'b0, mk(31,0,3,2), 16'h0, 3'd0, 5'd0},
    {1'b0, mk(3,1,0,16), 16'h0, 3'd0, 5'd0},
    {1'b0, mk(6,0,31,17),16'h0, 3'd0, 5'd0},
    {1'b0, mk(8,1,0,2),  16'h0, 3'd0, 5'd0},
    {1'b1, mk(4,0,1,2),  mk(9,1,1,2), 3'd0, 5'd0},
    {1'b0, mk(5,0,2,1),  16'h0, 3'd1, 5'd1},
    {1'b0, mk(7,1,4,2),  16'h0, 3'd2, 5'd2},
    {1'b0, mk(7,1,4,4),  16'h0, 3'd3, 5'd16},
    {1'b0, mk(5,0,2,1),  16'h0, 3'd4, 5'd4},
    {1'b0, mk(5,0,2,1),  16'h0, 3'd5, 5'd8},
    {1'b0, mk(7,1,4,4),  16'h0, 3'd6, 5'd16}
  };

  logic clk, rst_n, start, rt_to_rt;
  logic [15:0] cmd1_word, cmd2_word;
  logic [TO_W-1:0] resp_timeout;
  logic tx_valid, tx_cmd, tx_ready, tx_pop;
  logic [15:0] tx_word, tx_fifo_word;
  logic rx_valid, rx_stat_sync, rx_bad;
  logic [15:0] rx_word, rxf_word, stat1, stat2;
  logic rxf_push, valmess, error;
  logic [4:0] err_flags;

  int checks = 0, fails = 0;
  int txcnt = 0, popcnt = 0, pushcnt = 0, ncmd = 0, passbad = 0, cycles = 0;
  logic [31:0] cmdlog = '0;

  bc_msg_seq #(.TO_W(TO_W)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign tx_fifo_word = 16'hC000 | 16'(popcnt[7:0]);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (tx_valid && tx_ready) begin
      txcnt <= txcnt + 1;
      if (tx_cmd) begin
        cmdlog <= {cmdlog[15:0], tx_word};
        ncmd   <= ncmd + 1;
      end else if (tx_word != tx_fifo_word) begin
        passbad <= passbad + 1;
      end
    end
    if (tx_pop) popcnt <= popcnt + 1;
    if (rxf_push) begin
      pushcnt <= pushcnt + 1;
      if (rxf_word != rx_word) passbad <= passbad + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input bit ssync, input bit bad);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w; rx_stat_sync = ssync; rx_bad = bad;
    @(negedge clk);
    rx_valid = 1'b0; rx_bad = 1'b0;
    @(negedge clk);
  endtask

  function automatic int nw(input logic [15:0] c);
    if (c[9:5] == 5'd0 || c[9:5] == 5'd31) return c[4] ? 1 : 0;
    return (c[4:0] == 0) ? 32 : int'(c[4:0]);
  endfunction

  function automatic string req_of(input int f, input bit bc);
    case (f)
      1: return "R8";
      2: return "R9";
      3: return "R10";
      4, 5: return "R12";
      6: return "R11";
      default: return bc ? "R3" : "R6";
    endcase
  endfunction

  task automatic run_row(input int row);
    logic [40:0] v;
    bit rt2, bc, xm;
    logic [15:0] c1, c2, sa, sb;
    int f, n, bcd, ntx, nr, tx0, pop0, push0, cmd0, guard;
    logic [4:0] ee, a;
    v = VEC[row];
    rt2 = v[40]; c1 = v[39:24]; c2 = v[23:8]; f = int'(v[7:5]); ee = v[4:0];
    n = nw(c1); bc = (c1[15:11] == 5'd31); xm = c1[10];
    bcd = (!rt2 && !xm) ? n : 0;
    ntx = 1 + int'(rt2) + bcd;
    nr  = rt2 ? nw(c2) : (xm ? n : 0);
    if (f == 3) nr = nr - 1;
    sa = '0; sb = '0;
    @(negedge clk);
    rt_to_rt = rt2; cmd1_word = c1; cmd2_word = c2;
    tx0 = txcnt; pop0 = popcnt; push0 = pushcnt; cmd0 = ncmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (txcnt - tx0 < ntx && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    if (f != 1 && !(bc && !rt2)) begin
      a = rt2 ? c2[15:11] : c1[15:11];
      if (f == 2) a = a ^ 5'd1;
      sa = {a, 11'(row * 37)};
      send(sa, f != 5, f == 4);
      if (f == 0 || f == 3 || f == 6) begin
        for (int k = 0; k < nr; k++) send(16'h1000 + 16'(k) + 16'(row << 8), 1'b0, 1'b0);
        if (rt2 && !bc && f == 0) begin
          sb = {c1[15:11], 11'(row * 37 + 1)};
          send(sb, 1'b1, 1'b0);
        end
      end
    end
    if (f == 6) begin
      repeat (5) @(negedge clk);
      chk(valmess == 1'b1, "R11", 32'(valmess), 32'd1);
      send(16'h0BAD, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
    end else begin
      repeat (40) @(negedge clk);
    end
    chk(valmess == (ee == 0), req_of(f, bc), 32'(valmess), 32'(ee == 0));
    chk(error == (ee != 0), req_of(f, bc), 32'(error), 32'(ee != 0));
    chk(err_flags == ee, "R7", 32'(err_flags), 32'(ee));
    chk(popcnt - pop0 == bcd, "R2", 32'(popcnt - pop0), 32'(bcd));
    if (f == 0 || f == 3 || f == 6)
      chk(pushcnt - push0 == nr, "R5", 32'(pushcnt - push0), 32'(nr));
    if (rt2) begin
      chk(ncmd - cmd0 == 2 && cmdlog == {c1, c2}, "R1", cmdlog, {c1, c2});
    end else begin
      chk(ncmd - cmd0 == 1 && cmdlog[15:0] == c1, "R1", 32'(cmdlog[15:0]), 32'(c1));
    end
    if (f == 0 && !bc) begin
      if (rt2) begin
        chk(stat2 == sa, "R4", 32'(stat2), 32'(sa));
        chk(stat1 == sb, "R4", 32'(stat1), 32'(sb));
      end else begin
        chk(stat1 == sa, "R4", 32'(stat1), 32'(sa));
      end
    end
  endtask

  initial begin
    int tx0;
    rst_n = 1'b0; start = 1'b0; rt_to_rt = 1'b0;
    cmd1_word = '0; cmd2_word = '0; resp_timeout = 16'd20;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_stat_sync = 1'b0; rx_bad = 1'b0; rx_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(valmess == 1'b0, "R6", 32'(valmess), 32'd0);
    chk(error == 1'b0 && err_flags == 5'd0, "R7", 32'(err_flags), 32'd0);
    chk(tx_valid == 1'b0, "R1", 32'(tx_valid), 32'd0);

    for (int r = 0; r < NV; r++) run_row(r);

    // R1: level held high starts one message only (broadcast mode code without data)
    @(negedge clk);
    rt_to_rt = 1'b0; cmd1_word = mk(31, 1, 0, 1);
    tx0 = txcnt;
    start = 1'b1;
    repeat (20) @(negedge clk);
    chk(txcnt - tx0 == 1, "R1", 32'(txcnt - tx0), 32'd1);
    chk(valmess == 1'b1 && err_flags == 5'd0, "R3", 32'(valmess), 32'd1);
    start = 1'b0;
    repeat (2) @(negedge clk);

    chk(passbad == 0, "R5", 32'(passbad), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule